// File: doc/BRIEF.md
# Clock-Calendar Counter with Daylight-Saving Adjustment

This block holds the wall-clock time and calendar date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle pulse arriving once per second advances the count. Carries ripple from seconds up through the year, and month lengths and leap years are honoured. Software reaches the seven time fields and one control byte through a small synchronous register port. Each field can be presented and accepted either as plain binary or as packed BCD. The hours can be shown in a 24-hour or a 12-hour form with a PM flag.

A freeze bit in the control byte stops all advancing, so software can load a new time without a carry landing halfway through. When the daylight-saving enable is on, the block checks at each midnight whether the new day is the first Sunday of the spring month or the last Sunday of the autumn month. On the spring day, 01:59:59 is followed by 03:00:00. On the autumn day, 01:59:59 is followed once by 01:00:00. After every completed advance the block raises a one-cycle update-ended strobe.

The counts are kept internally in binary with a 0–23 hour. The selected format is applied only when a field is read or written.

Top module: `rtc_calendar_core`

## Requirements
- R1: An asynchronous reset (rst_n low) sets the time to 00:00:00, day of week 1, date 1, month 1 and year 0, and drives upd_done low. Reset leaves the control byte unchanged.
- R2: Register addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control. The control bits are: bit 0 freeze, bit 1 binary format, bit 2 24-hour mode, bit 3 daylight-saving enable; bits 7:4 read as 0. A write takes effect at the clock edge that samples wr_en. rd_data shows the field selected by addr one clock edge later.
- R3: With freeze = 0, each tick adds one second, with carries into minutes, hours and days. The date wraps after 30 or 31 days according to the month. February has 29 days when year mod 4 = 0, and 28 days otherwise. The month wraps from 12 to 1, and the year wraps from 99 to 0.
- R4: With freeze = 1, a tick changes no time field and produces no strobe. Register writes still take effect.
- R5: With control bit 1 = 1, fields are read and written as plain binary. With bit 1 = 0, they use packed BCD (tens in bits 7:4, units in bits 3:0). Changing the bit re-encodes the stored time without changing it.
- R6: In 12-hour mode (control bit 2 = 0), bit 7 of the hours byte is the PM flag and bits 6:0 hold 12, 1, …, 11. 11:59:59 AM rolls to 12:00:00 PM, and 11:59:59 PM rolls to 12:00:00 AM. In 24-hour mode the hours byte holds 0–23.
- R7: Day of week counts 1 to 7, with 1 meaning Sunday. It advances at midnight and wraps from 7 to 1.
- R8: If the spring condition was latched at the last midnight (month 4, Sunday, date ≤ 7, enable set), the tick at 01:59:59 leads to 03:00:00.
- R9: If the autumn condition was latched at the last midnight (month 10, Sunday, date + 7 beyond the month length, enable set), the first tick at 01:59:59 leads to 01:00:00. Any later pass through 01:59:59 that day advances normally.
- R10: The Sunday conditions are latched only at the midnight advance. If the daylight-saving enable is 0 at that moment, no jump happens that day, even if the enable is set afterwards.
- R11: upd_done is high for exactly the one cycle in which the advanced time first appears. A register write in the same cycle as a tick takes precedence: the tick is dropped and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | 3 | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data in the selected format |
| rd_data | output | 8 | Registered read data for addr |
| upd_done | output | 1 | One-cycle update-ended strobe |

## Verification
A tick sampled at a rising edge makes the new time and the upd_done strobe visible right after that same edge. A write is likewise visible in state right after the edge that samples it. rd_data lags addr by one edge. The bench drives every input on falling edges and reads each result on the next falling edge, which is the first point where the registered value is due. It reads upd_done on the falling edge right after the tick edge, and again one cycle later to confirm the strobe has dropped. Each daylight-saving case first ticks through a real midnight, so the Sunday test is latched by the design itself, and only then loads 01:59:59.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int FIELD_CNT = 7;
    localparam int ADDR_W    = 3;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [4:0] hr;
        logic [2:0] dow;
        logic [4:0] date;
        logic [3:0] mon;
        logic [6:0] yr;
    } time_t;

    typedef struct packed {
        logic dst_en;
        logic h24;
        logic bin;
        logic freeze;
    } ctrl_t;

    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        logic [3:0] tens;
        logic [3:0] ones;
        tens = 4'(v / 7'd10);
        ones = 4'(v % 7'd10);
        return {tens, ones};
    endfunction

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return 7'({3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]});
    endfunction

    function automatic logic [4:0] month_days(input logic [3:0] m, input logic [6:0] y);
        case (m)
            4'd2:                      return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

    function automatic logic [6:0] field_val(input time_t t, input logic [2:0] f);
        case (f)
            3'd0:    return t.sec;
            3'd1:    return t.min;
            3'd2:    return {2'b00, t.hr};
            3'd3:    return {4'b0000, t.dow};
            3'd4:    return {2'b00, t.date};
            3'd5:    return {3'b000, t.mon};
            default: return t.yr;
        endcase
    endfunction

endpackage

// File: rtl/rtc_view_enc.sv
module rtc_view_enc
    import rtc_pkg::*;
#(
    parameter bit IS_HOUR = 1'b0
) (
    input  logic [6:0] v,
    input  logic       bin_mode,
    input  logic       h24,
    output logic [7:0] q
);
    logic       hour12;
    logic       pm;
    logic [6:0] h12;

    always_comb begin
        hour12 = IS_HOUR && !h24;
        pm     = (v >= 7'd12);
        h12    = pm ? v - 7'd12 : v;
        if (h12 == 7'd0) h12 = 7'd12;
        if (hour12)
            q = {pm, bin_mode ? h12 : bin2bcd(h12)[6:0]};
        else
            q = bin_mode ? {1'b0, v} : bin2bcd(v);
    end
endmodule

// File: rtl/rtc_write_dec.sv
module rtc_write_dec
    import rtc_pkg::*;
(
    input  logic [7:0] d,
    input  logic       bin_mode,
    input  logic       h24,
    input  logic       is_hour,
    output logic [6:0] v
);
    logic [6:0] raw;
    logic [6:0] base;

    always_comb begin
        if (is_hour && !h24) begin
            raw  = bin_mode ? d[6:0] : bcd2bin({1'b0, d[6:0]});
            base = (raw == 7'd12) ? 7'd0 : raw;
            v    = base + (d[7] ? 7'd12 : 7'd0);
        end else begin
            raw  = bin_mode ? d[6:0] : bcd2bin(d);
            base = raw;
            v    = raw;
        end
    end
endmodule

// File: rtl/rtc_next_second.sv
module rtc_next_second
    import rtc_pkg::*;
#(
    parameter int SPRING_MONTH = 4,
    parameter int FALL_MONTH   = 10,
    parameter int DST_HOUR     = 1,
    parameter int YEAR_LAST    = 99
) (
    input  time_t cur,
    input  logic  spr_arm,
    input  logic  fal_arm,
    input  logic  dst_en,
    output time_t nxt,
    output logic  spr_next,
    output logic  fal_next
);
    localparam logic [4:0] JUMP_HR  = 5'(DST_HOUR);
    localparam logic [4:0] SPRING_TO = 5'(DST_HOUR + 2);

    logic       at_jump;
    logic       new_day;
    logic [4:0] md_nxt;

    always_comb begin
        nxt      = cur;
        spr_next = spr_arm;
        fal_next = fal_arm;
        new_day  = 1'b0;
        at_jump  = dst_en && cur.hr == JUMP_HR && cur.min == 7'd59 && cur.sec == 7'd59;

        if (at_jump && spr_arm) begin
            nxt.hr = SPRING_TO; nxt.min = '0; nxt.sec = '0;
            spr_next = 1'b0;
        end else if (at_jump && fal_arm) begin
            nxt.hr = JUMP_HR; nxt.min = '0; nxt.sec = '0;
            fal_next = 1'b0;
        end else if (cur.sec < 7'd59) begin
            nxt.sec = cur.sec + 7'd1;
        end else begin
            nxt.sec = '0;
            if (cur.min < 7'd59) begin
                nxt.min = cur.min + 7'd1;
            end else begin
                nxt.min = '0;
                if (cur.hr < 5'd23) begin
                    nxt.hr = cur.hr + 5'd1;
                end else begin
                    nxt.hr  = '0;
                    new_day = 1'b1;
                end
            end
        end

        if (new_day) begin
            nxt.dow = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
            if (cur.date >= month_days(cur.mon, cur.yr)) begin
                nxt.date = 5'd1;
                if (cur.mon >= 4'd12) begin
                    nxt.mon = 4'd1;
                    nxt.yr  = (cur.yr >= 7'(YEAR_LAST)) ? 7'd0 : cur.yr + 7'd1;
                end else begin
                    nxt.mon = cur.mon + 4'd1;
                end
            end else begin
                nxt.date = cur.date + 5'd1;
            end
        end

        md_nxt = month_days(nxt.mon, nxt.yr);
        if (new_day) begin
            spr_next = dst_en && nxt.mon == 4'(SPRING_MONTH) && nxt.dow == 3'd1
                       && nxt.date <= 5'd7;
            fal_next = dst_en && nxt.mon == 4'(FALL_MONTH) && nxt.dow == 3'd1
                       && ({1'b0, nxt.date} + 6'd7 > {1'b0, md_nxt});
        end
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int SPRING_MONTH = 4,
    parameter int FALL_MONTH   = 10,
    parameter int DST_HOUR     = 1,
    parameter int YEAR_LAST    = 99
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       upd_done
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(FIELD_CNT);

    typedef struct packed {
        time_t      tm;
        logic       spr;
        logic       fal;
        logic       strobe;
        logic [7:0] rdata;
    } state_t;

    localparam state_t ST_RST = '{
        tm: '{sec: 7'd0, min: 7'd0, hr: 5'd0, dow: 3'd1, date: 5'd1, mon: 4'd1, yr: 7'd0},
        spr: 1'b0, fal: 1'b0, strobe: 1'b0, rdata: 8'd0};

    state_t st_d, st_q;
    ctrl_t  ctl_d, ctl_q;

    time_t      tm_adv;
    logic       spr_adv, fal_adv;
    logic [6:0] wval;
    logic [7:0] view [FIELD_CNT+1];

    rtc_next_second #(
        .SPRING_MONTH(SPRING_MONTH), .FALL_MONTH(FALL_MONTH),
        .DST_HOUR(DST_HOUR), .YEAR_LAST(YEAR_LAST)
    ) u_adv (
        .cur(st_q.tm), .spr_arm(st_q.spr), .fal_arm(st_q.fal), .dst_en(ctl_q.dst_en),
        .nxt(tm_adv), .spr_next(spr_adv), .fal_next(fal_adv)
    );

    rtc_write_dec u_wdec (
        .d(wr_data), .bin_mode(ctl_q.bin), .h24(ctl_q.h24),
        .is_hour(addr == 3'd2), .v(wval)
    );

    for (genvar f = 0; f < FIELD_CNT; f++) begin : g_view
        rtc_view_enc #(.IS_HOUR(f == 2)) u_enc (
            .v(field_val(st_q.tm, 3'(f))), .bin_mode(ctl_q.bin), .h24(ctl_q.h24),
            .q(view[f])
        );
    end
    assign view[FIELD_CNT] = {4'b0000, ctl_q};

    always_comb begin
        st_d        = st_q;
        ctl_d       = ctl_q;
        st_d.strobe = 1'b0;
        st_d.rdata  = view[addr];
        if (wr_en) begin
            case (addr)
                3'd0: st_d.tm.sec  = wval;
                3'd1: st_d.tm.min  = wval;
                3'd2: st_d.tm.hr   = 5'(wval);
                3'd3: st_d.tm.dow  = 3'(wval);
                3'd4: st_d.tm.date = 5'(wval);
                3'd5: st_d.tm.mon  = 4'(wval);
                3'd6: st_d.tm.yr   = wval;
                default: ctl_d     = ctrl_t'(wr_data[3:0]);
            endcase
        end else if (tick && !ctl_q.freeze) begin
            st_d.tm     = tm_adv;
            st_d.spr    = spr_adv;
            st_d.fal    = fal_adv;
            st_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign rd_data  = st_q.rdata;
    assign upd_done = st_q.strobe;

    logic unused_ok;
    assign unused_ok = &{1'b0, CTRL_ADDR};
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic       upd_done,
    input time_t      tm,
    input ctrl_t      ctl,
    input logic       spr
);
    a_r4_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.freeze && !wr_en) |=> $stable(tm));

    a_r11_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> $past(tick && !wr_en && !ctl.freeze));

    a_r1_ctrl_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl) |-> $past(wr_en && addr == 3'd7));

    a_r3_sec_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tm.sec) |-> (upd_done || $past(wr_en)));

    a_r8_three_oclock_source: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && tm.hr == 5'd3 && tm.min == 7'd0 && tm.sec == 7'd0)
        |-> ($past(tm.hr) == 5'd2 || $past(spr)));
endmodule

bind rtc_calendar_core rtc_calendar_chk i_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .upd_done(upd_done), .tm(st_q.tm), .ctl(ctl_q), .spr(st_q.spr)
);

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       upd_done;

    int n_tot = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_calendar_core i_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .upd_done(upd_done)
    );

    // {ctrl, before: sec min hr dow date mon yr, after: sec min hr dow date mon yr}
    localparam int NV = 9;
    localparam logic [119:0] VEC [NV] = '{
        {8'h04, 56'h56_34_12_03_15_06_24, 56'h57_34_12_03_15_06_24}, // R3 BCD 24h
        {8'h04, 56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00}, // R3 R7 year wrap
        {8'h06, 56'h3B_3B_17_02_1C_02_18, 56'h00_00_00_03_1D_02_18}, // R3 R5 leap Feb
        {8'h06, 56'h3B_3B_17_02_1C_02_17, 56'h00_00_00_03_01_03_17}, // R3 R5 non-leap
        {8'h00, 56'h59_59_91_04_30_04_25, 56'h00_00_12_05_01_05_25}, // R6 PM to AM
        {8'h00, 56'h59_59_11_01_10_01_00, 56'h00_00_92_01_10_01_00}, // R6 AM to PM
        {8'h02, 56'h3B_3B_8C_06_05_03_01, 56'h00_00_81_06_05_03_01}, // R6 R5 12 to 1 PM
        {8'h04, 56'h59_59_09_01_30_09_10, 56'h00_00_10_01_30_09_10}, // R5 BCD carry
        {8'h04, 56'h59_59_23_05_30_09_10, 56'h00_00_00_06_01_10_10}  // R3 30-day month
    };

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic do_tick(output logic s);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        s = upd_done;
    endtask

    task automatic set_time(input logic [7:0] c, input logic [55:0] t);
        wr(3'd7, c | 8'h01);
        for (int f = 0; f < 7; f++) wr(3'(f), t[55-8*f -: 8]);
        wr(3'd7, c);
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tot++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic       s;
        pulse_reset();

        // R1 reset values (format set first: BCD, 24h)
        check("R1 strobe after reset", {7'd0, upd_done}, 8'h00);
        wr(3'd7, 8'h04);
        for (int f = 0; f < 7; f++) begin
            rd(3'(f), r);
            check($sformatf("R1 reset field %0d", f), r, (f == 3 || f == 4 || f == 5) ? 8'h01 : 8'h00);
        end

        // vector walk: R3 R5 R6 R7 R11
        for (int i = 0; i < NV; i++) begin
            logic [119:0] v;
            v = VEC[i];
            set_time(v[119:112], v[111:56]);
            do_tick(s);
            check($sformatf("R11 strobe vec %0d", i), {7'd0, s}, 8'h01);
            for (int f = 0; f < 7; f++) begin
                rd(3'(f), r);
                check($sformatf("R3/R5/R6/R7 vec %0d field %0d", i, f), r, v[55-8*f -: 8]);
            end
        end

        // R11 strobe lasts one cycle
        set_time(8'h04, 56'h10_00_00_01_01_01_00);
        do_tick(s);
        check("R11 strobe high", {7'd0, s}, 8'h01);
        @(negedge clk);
        check("R11 strobe drops", {7'd0, upd_done}, 8'h00);

        // R11 write beats tick in same cycle
        @(negedge clk);
        addr = 3'd0; wr_data = 8'h30; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check("R11 no strobe on write+tick", {7'd0, upd_done}, 8'h00);
        rd(3'd0, r);
        check("R11 written sec kept", r, 8'h30);

        // R4 freeze
        wr(3'd7, 8'h05);
        wr(3'd0, 8'h42);
        do_tick(s);
        check("R4 no strobe when frozen", {7'd0, s}, 8'h00);
        rd(3'd0, r);
        check("R4 sec held when frozen", r, 8'h42);
        wr(3'd1, 8'h17);
        rd(3'd1, r);
        check("R4 write while frozen", r, 8'h17);

        // R1 control survives reset, time does not
        pulse_reset();
        rd(3'd7, r);
        check("R1 ctrl kept through reset", r, 8'h05);
        rd(3'd0, r);
        check("R1 sec cleared by reset", r, 8'h00);

        // R5 / R6 re-encoding of stored hour
        wr(3'd7, 8'h06);
        wr(3'd2, 8'h17);
        wr(3'd7, 8'h04);
        rd(3'd2, r);
        check("R5 binary 23 reads as BCD", r, 8'h23);
        wr(3'd7, 8'h00);
        rd(3'd2, r);
        check("R6 23h reads 11 PM", r, 8'h91);
        rd(3'd7, r);
        check("R2 ctrl readback", r, 8'h00);

        // R8 spring jump: midnight into Sun 7 Apr
        set_time(8'h0C, 56'h59_59_23_07_06_04_24);
        do_tick(s);
        rd(3'd3, r);
        check("R7 Sat to Sun", r, 8'h01);
        wr(3'd2, 8'h01); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        do_tick(s);
        rd(3'd2, r); check("R8 spring hour", r, 8'h03);
        rd(3'd1, r); check("R8 spring min", r, 8'h00);
        rd(3'd0, r); check("R8 spring sec", r, 8'h00);

        // R9 autumn fallback once: midnight into Sun 28 Oct
        set_time(8'h0C, 56'h59_59_23_07_27_10_24);
        do_tick(s);
        wr(3'd2, 8'h01); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        do_tick(s);
        rd(3'd2, r); check("R9 fall hour", r, 8'h01);
        rd(3'd1, r); check("R9 fall min", r, 8'h00);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        do_tick(s);
        rd(3'd2, r); check("R9 second pass hour", r, 8'h02);

        // R10 enable off at midnight: no jump later that day
        set_time(8'h04, 56'h59_59_23_07_06_04_24);
        do_tick(s);
        wr(3'd7, 8'h0C);
        wr(3'd2, 8'h01); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        do_tick(s);
        rd(3'd2, r); check("R10 no jump when disabled at midnight", r, 8'h02);

        // R8 not on a later Sunday in April
        set_time(8'h0C, 56'h59_59_23_07_13_04_24);
        do_tick(s);
        wr(3'd2, 8'h01); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        do_tick(s);
        rd(3'd2, r); check("R8 second Sunday no jump", r, 8'h02);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule